// File: doc/BRIEF.md
# Single/Double Precision Converter with NaN Quieting

This block converts one floating-point operand per cycle between the 32-bit and 64-bit binary formats. When `widen_i` is high it reads a single-precision value from `operand_i[31:0]` and returns the double-precision value. When `widen_i` is low it reads a double-precision value from `operand_i` and returns the single-precision value in `result_o[31:0]`. Each result appears one clock after the input strobe.

NaNs are not replaced by a canonical NaN. Their sign and payload move across formats by fixed bit rules. The fraction is shifted up with zero fill when widening and truncated when narrowing. A signaling NaN leaves the block as a quiet NaN and raises the invalid flag. When the invalid condition is unmasked, no result is delivered and a fault pulse is raised instead. For narrowing, finite values are rounded to nearest even. Values that are out of range saturate to infinity (overflow) or flush to signed zero (underflow).

Top module: `fp_prec_conv`

## Requirements
- R1: A NaN is widened as follows: sign kept, exponent set to 0x7FF, and result fraction = source 23-bit fraction followed by 29 zero bits.
- R2: A NaN is narrowed as follows: sign kept, exponent set to 0xFF, and result fraction = source fraction bits [51:29], so the 29 low bits are dropped.
- R3: A signaling NaN is a NaN whose fraction MSB is 0 (bit 22 in single format, bit 51 in double format). For every NaN output, that fraction MSB is 1.
- R4: A quiet NaN input is converted with valid_o high and all flags and fault_o low.
- R5: A signaling NaN input sets invalid_o. When invalid_mask_i is 1, the quieted result is delivered with valid_o high and fault_o low.
- R6: When a signaling NaN arrives with invalid_mask_i = 0, valid_o stays low, fault_o and invalid_o are high for that one result cycle, and no other flag is set.
- R7: A normal single value is widened exactly: exponent + 896, fraction followed by 29 zero bits, and no flags.
- R8: A normal double value is narrowed with exponent - 896 and the fraction rounded to nearest even on bits [28:0]. A rounding carry increments the exponent. Any dropped nonzero bit sets inexact_o.
- R9: When the narrowed exponent after rounding is 255 or more, the result is a signed infinity and overflow_o and inexact_o are set.
- R10: When a nonzero finite double has a narrowed exponent below 1 (this includes double subnormals), the result is signed zero and underflow_o and inexact_o are set.
- R11: Infinities and zeros keep their sign and convert to the matching encoding with no flags. A single subnormal input is widened to signed zero with no flags.
- R12: Outputs are registered one cycle after valid_i. In a cycle with no valid_i before it, valid_o, fault_o and all flags are 0. After reset all of them are 0.
- R13: A narrowed result has result_o[63:32] = 0. A widening conversion ignores operand_i[63:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| widen_i | input | 1 | 1: single to double, 0: double to single |
| invalid_mask_i | input | 1 | 1: invalid is masked and a quiet result is delivered |
| operand_i | input | 64 | Source operand; [31:0] only when widening |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Converted value; single results in [31:0] |
| invalid_o | output | 1 | Signaling NaN seen |
| overflow_o | output | 1 | Narrowed result saturated to infinity |
| underflow_o | output | 1 | Narrowed result flushed to zero |
| inexact_o | output | 1 | Narrowing lost nonzero bits |
| fault_o | output | 1 | Unmasked invalid; no result delivered |

## Verification
Two functions can act on the same narrowing operation: round-to-nearest-even can carry into the exponent, and that carry can push the exponent out of range. The bench triggers this with 0x47EFFFFFF0000000. Its unrounded exponent of 254 is still legal, but rounding up carries it to 255. The scoreboard then requires a signed infinity with overflow and inexact set, not a finite value of maximum magnitude. The same path is also checked without overflow (0x3FFFFFFFF0000000 gives 2.0) and at a tie that rounds down.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned SP_EXP_W  = 8;
  localparam int unsigned SP_FRAC_W = 23;
  localparam int unsigned DP_EXP_W  = 11;
  localparam int unsigned DP_FRAC_W = 52;
  localparam int unsigned SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int unsigned DP_W      = 1 + DP_EXP_W + DP_FRAC_W;
  localparam int unsigned FRAC_DIFF = DP_FRAC_W - SP_FRAC_W;
  localparam int unsigned SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
  localparam int unsigned DP_BIAS   = (1 << (DP_EXP_W - 1)) - 1;
  localparam int unsigned BIAS_DIFF = DP_BIAS - SP_BIAS;

  typedef struct packed {
    logic nan;
    logic snan;
    logic inf;
    logic zero;
    logic sub;
  } fp_class_t;
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify
  import fpc_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] val_i,
  output fp_class_t             cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max, exp_min, frac_nz;

  assign exp_f   = val_i[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f  = val_i[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    cls_o.nan  = exp_max & frac_nz;
    cls_o.snan = exp_max & frac_nz & ~frac_f[FRAC_W-1];
    cls_o.inf  = exp_max & ~frac_nz;
    cls_o.zero = exp_min & ~frac_nz;
    cls_o.sub  = exp_min & frac_nz;
  end
endmodule

// File: rtl/fpc_widen.sv
module fpc_widen
  import fpc_pkg::*;
(
  input  logic [SP_W-1:0] src_i,
  input  fp_class_t       cls_i,
  output logic [DP_W-1:0] res_o
);
  logic                 sgn;
  logic [SP_EXP_W-1:0]  exp_s;
  logic [SP_FRAC_W-1:0] frac_s, frac_q;
  logic [DP_EXP_W-1:0]  exp_d;

  assign sgn    = src_i[SP_W-1];
  assign exp_s  = src_i[SP_W-2:SP_FRAC_W];
  assign frac_s = src_i[SP_FRAC_W-1:0];
  // quiet bit forced on signaling input
  assign frac_q = frac_s | {cls_i.snan, {(SP_FRAC_W-1){1'b0}}};
  assign exp_d  = DP_EXP_W'(exp_s) + DP_EXP_W'(BIAS_DIFF);

  always_comb begin
    if (cls_i.nan)
      res_o = {sgn, {DP_EXP_W{1'b1}}, frac_q, {FRAC_DIFF{1'b0}}};
    else if (cls_i.inf)
      res_o = {sgn, {DP_EXP_W{1'b1}}, {DP_FRAC_W{1'b0}}};
    else if (cls_i.zero || cls_i.sub)
      res_o = {sgn, {(DP_W-1){1'b0}}};
    else
      res_o = {sgn, exp_d, frac_s, {FRAC_DIFF{1'b0}}};
  end
endmodule

// File: rtl/fpc_narrow.sv
module fpc_narrow
  import fpc_pkg::*;
(
  input  logic [DP_W-1:0] src_i,
  input  fp_class_t       cls_i,
  output logic [SP_W-1:0] res_o,
  output logic            ovf_o,
  output logic            unf_o,
  output logic            inx_o
);
  localparam int unsigned EW = DP_EXP_W + 2;

  logic                 sgn;
  logic [DP_EXP_W-1:0]  exp_d;
  logic [DP_FRAC_W-1:0] frac_d;
  logic [SP_FRAC_W-1:0] frac_q;
  logic [EW-1:0]        exp_n, exp_r;
  logic                 guard, sticky, lsb, rnd_up, carry, finite;
  logic [SP_FRAC_W:0]   mant;

  assign sgn    = src_i[DP_W-1];
  assign exp_d  = src_i[DP_W-2:DP_FRAC_W];
  assign frac_d = src_i[DP_FRAC_W-1:0];
  assign frac_q = frac_d[DP_FRAC_W-1:FRAC_DIFF] | {cls_i.snan, {(SP_FRAC_W-1){1'b0}}};

  assign guard  = frac_d[FRAC_DIFF-1];
  assign sticky = |frac_d[FRAC_DIFF-2:0];
  assign lsb    = frac_d[FRAC_DIFF];
  assign rnd_up = guard & (sticky | lsb);
  assign mant   = {1'b0, frac_d[DP_FRAC_W-1:FRAC_DIFF]} + (SP_FRAC_W+1)'(rnd_up);
  assign carry  = mant[SP_FRAC_W];
  assign exp_n  = EW'(exp_d) - EW'(BIAS_DIFF);
  assign exp_r  = exp_n + EW'(carry);
  assign finite = ~cls_i.nan & ~cls_i.inf & ~cls_i.zero;

  always_comb begin
    ovf_o = 1'b0;
    unf_o = 1'b0;
    inx_o = 1'b0;
    if (cls_i.nan)
      res_o = {sgn, {SP_EXP_W{1'b1}}, frac_q};
    else if (cls_i.inf)
      res_o = {sgn, {SP_EXP_W{1'b1}}, {SP_FRAC_W{1'b0}}};
    else if (cls_i.zero)
      res_o = {sgn, {(SP_W-1){1'b0}}};
    else if (cls_i.sub || ($signed(exp_n) < $signed(EW'(1)))) begin
      res_o = {sgn, {(SP_W-1){1'b0}}};
      unf_o = finite;
      inx_o = finite;
    end else if ($signed(exp_r) >= $signed(EW'((1 << SP_EXP_W) - 1))) begin
      res_o = {sgn, {SP_EXP_W{1'b1}}, {SP_FRAC_W{1'b0}}};
      ovf_o = 1'b1;
      inx_o = 1'b1;
    end else begin
      res_o = {sgn, exp_r[SP_EXP_W-1:0], mant[SP_FRAC_W-1:0]};
      inx_o = guard | sticky;
    end
  end
endmodule

// File: rtl/fp_prec_conv.sv
module fp_prec_conv
  import fpc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            widen_i,
  input  logic            invalid_mask_i,
  input  logic [DP_W-1:0] operand_i,
  output logic            valid_o,
  output logic [DP_W-1:0] result_o,
  output logic            invalid_o,
  output logic            overflow_o,
  output logic            underflow_o,
  output logic            inexact_o,
  output logic            fault_o
);
  fp_class_t       cls_sp, cls_dp;
  logic [DP_W-1:0] wide_res;
  logic [SP_W-1:0] narrow_res;
  logic            n_ovf, n_unf, n_inx;
  logic            snan_in, trap;

  fpc_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_cls_sp (
    .val_i(operand_i[SP_W-1:0]), .cls_o(cls_sp));
  fpc_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_cls_dp (
    .val_i(operand_i), .cls_o(cls_dp));

  fpc_widen u_widen (.src_i(operand_i[SP_W-1:0]), .cls_i(cls_sp), .res_o(wide_res));

  fpc_narrow u_narrow (
    .src_i(operand_i), .cls_i(cls_dp), .res_o(narrow_res),
    .ovf_o(n_ovf), .unf_o(n_unf), .inx_o(n_inx));

  assign snan_in = widen_i ? cls_sp.snan : cls_dp.snan;
  assign trap    = snan_in & ~invalid_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      fault_o     <= 1'b0;
      invalid_o   <= 1'b0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      inexact_o   <= 1'b0;
      result_o    <= '0;
    end else begin
      valid_o     <= valid_i & ~trap;
      fault_o     <= valid_i & trap;
      invalid_o   <= valid_i & snan_in;
      overflow_o  <= valid_i & ~widen_i & n_ovf;
      underflow_o <= valid_i & ~widen_i & n_unf;
      inexact_o   <= valid_i & ~widen_i & n_inx;
      if (valid_i && !trap)
        result_o <= widen_i ? wide_res : {{(DP_W-SP_W){1'b0}}, narrow_res};
    end
  end

  p_fault_blocks_result_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!valid_o && invalid_o && !overflow_o && !underflow_o));
  p_ovf_inexact_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> inexact_o);
  p_unf_inexact_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> inexact_o);
  p_latency_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || fault_o) |-> $past(valid_i));
  p_quiet_wide_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(widen_i) && (&result_o[62:52]) && (|result_o[51:0])) |-> result_o[51]);
  p_quiet_narrow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(widen_i) && (&result_o[30:23]) && (|result_o[22:0])) |-> result_o[22]);
  p_narrow_upper_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(widen_i)) |-> (result_o[63:32] == 32'h0));
endmodule

// File: tb/fp_prec_conv_tb_top.sv
module fp_prec_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, widen_i = 1'b0, mask_i = 1'b1;
  logic [63:0] op_i = '0;
  logic        valid_o, inv_o, ovf_o, unf_o, inx_o, fault_o;
  logic [63:0] res_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    string       tag;
    logic        vld;
    logic [63:0] res;
    logic [4:0]  flg; // {fault, invalid, overflow, underflow, inexact}
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  fp_prec_conv dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .widen_i(widen_i),
    .invalid_mask_i(mask_i), .operand_i(op_i), .valid_o(valid_o), .result_o(res_o),
    .invalid_o(inv_o), .overflow_o(ovf_o), .underflow_o(unf_o), .inexact_o(inx_o),
    .fault_o(fault_o));

  task automatic send(input string tag, input logic w, input logic m, input logic [63:0] op,
                      input logic ev, input logic [63:0] er, input logic [4:0] ef);
    exp_t e;
    @(negedge clk);
    valid_i = 1'b1; widen_i = w; mask_i = m; op_i = op;
    e.tag = tag; e.vld = ev; e.res = er; e.flg = ef;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    exp_t e;
    @(negedge clk);
    valid_i = 1'b0; op_i = 64'hFFFF_FFFF_FFFF_FFFF;
    e.tag = "R12"; e.vld = 1'b0; e.res = '0; e.flg = '0;
    sb_q.push_back(e);
  endtask

  // monitor: an item pushed before an edge is judged just after it
  always @(posedge clk) begin
    #2;
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      logic [4:0] got;
      e = sb_q.pop_front();
      got = {fault_o, inv_o, ovf_o, unf_o, inx_o};
      n_tests++;
      if (valid_o !== e.vld || got !== e.flg || (e.vld && res_o !== e.res)) begin
        n_fail++;
        $display("FAIL %s: valid=%b res=%h flags=%b, expected valid=%b res=%h flags=%b",
                 e.tag, valid_o, res_o, got, e.vld, e.res, e.flg);
      end
    end
  end

  initial begin
    #1;
    n_tests++;
    if (valid_o !== 1'b0 || fault_o !== 1'b0 || inv_o !== 1'b0 || ovf_o !== 1'b0 ||
        unf_o !== 1'b0 || inx_o !== 1'b0 || res_o !== 64'h0) begin
      n_fail++;
      $display("FAIL R12: reset state valid=%b fault=%b res=%h, expected all zero",
               valid_o, fault_o, res_o);
    end
    #24 rst_n = 1'b1;
    idle();
    // widening
    send("R7",  1, 1, 64'h0000_0000_3F80_0000, 1, 64'h3FF0_0000_0000_0000, 5'b00000);
    send("R7",  1, 1, 64'h0000_0000_C020_0000, 1, 64'hC004_0000_0000_0000, 5'b00000);
    send("R13", 1, 1, 64'hDEAD_BEEF_3F80_0000, 1, 64'h3FF0_0000_0000_0000, 5'b00000);
    send("R1_R4", 1, 1, 64'h0000_0000_7FC0_0001, 1, 64'h7FF8_0000_2000_0000, 5'b00000);
    send("R3_R5", 1, 1, 64'h0000_0000_FF80_0001, 1, 64'hFFF8_0000_2000_0000, 5'b01000);
    send("R6",  1, 0, 64'h0000_0000_7F80_0001, 0, 64'h0, 5'b11000);
    idle();
    send("R11", 1, 1, 64'h0000_0000_7F80_0000, 1, 64'h7FF0_0000_0000_0000, 5'b00000);
    send("R11", 1, 1, 64'h0000_0000_8000_0000, 1, 64'h8000_0000_0000_0000, 5'b00000);
    send("R11", 1, 1, 64'h0000_0000_8000_0001, 1, 64'h8000_0000_0000_0000, 5'b00000);
    // narrowing
    send("R8",  0, 1, 64'h3FF0_0000_0000_0000, 1, 64'h3F80_0000, 5'b00000);
    send("R8",  0, 1, 64'h3FF0_0000_1000_0000, 1, 64'h3F80_0000, 5'b00001);
    send("R8",  0, 1, 64'h3FF0_0000_3000_0000, 1, 64'h3F80_0002, 5'b00001);
    send("R8",  0, 1, 64'h3FF0_0000_1000_0001, 1, 64'h3F80_0001, 5'b00001);
    send("R8",  0, 1, 64'h3FFF_FFFF_F000_0000, 1, 64'h4000_0000, 5'b00001);
    send("R9",  0, 1, 64'h47F0_0000_0000_0000, 1, 64'h7F80_0000, 5'b00101);
    send("R9",  0, 1, 64'hC7EF_FFFF_F000_0000, 1, 64'hFF80_0000, 5'b00101);
    send("R10", 0, 1, 64'h3800_0000_0000_0000, 1, 64'h0000_0000, 5'b00011);
    send("R10", 0, 1, 64'h8000_0000_0000_0001, 1, 64'h8000_0000, 5'b00011);
    send("R10", 0, 1, 64'h3810_0000_0000_0000, 1, 64'h0080_0000, 5'b00000);
    send("R2_R4", 0, 1, 64'h7FF8_0000_2000_0000, 1, 64'h7FC0_0001, 5'b00000);
    send("R2_R3", 0, 1, 64'hFFF0_0000_0000_0001, 1, 64'hFFC0_0000, 5'b01000);
    send("R6",  0, 0, 64'h7FF4_0000_0000_0000, 0, 64'h0, 5'b11000);
    send("R11", 0, 1, 64'hFFF0_0000_0000_0000, 1, 64'hFF80_0000, 5'b00000);
    send("R11", 0, 1, 64'h8000_0000_0000_0000, 1, 64'h8000_0000, 5'b00000);
    send("R4",  0, 0, 64'h7FF8_0000_0000_0000, 1, 64'h7FC0_0000, 5'b00000);
    idle();
    idle();
    @(negedge clk);
    valid_i = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule